// File: doc/BRIEF.md
# Slot-Number Parallel Arbiter

This block sits on a repeater backplane in place of a daisy-chained grant line. Every board slot raises its own request line whenever one of its ports needs to be identified. While the arbitration phase input is high, the arbiter looks at all requests at once, picks the requesting slot with the lowest slot number, and drives that number onto a shared identification bus together with a valid flag. Each board compares the bus value with its own slot position and learns from its match line whether it holds the winning port.

The same arbiter serves both uses in the repeater: in the idle state, to find the receiving port, and in the transmit-collision state, to find the colliding port. The repeater control logic simply raises the phase input for the duration of either state. Priority depends only on the slot position, so an empty slot or a board that has been pulled out just leaves its request line low and has no other effect.

Top module: `slot_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, `bus_valid` is 0, `bus_id` is 0 and every bit of `slot_match` is 0.
- R2: On the first rising clock edge with `arb_phase` high, `bus_valid` low and at least one bit of `slot_req` set, the arbiter registers `bus_valid`=1 and `bus_id` = the lowest index of a set bit in `slot_req` (bit 0 is slot 0, the highest priority). The result is visible one cycle after that edge.
- R3: While `arb_phase` is high and `slot_req` is all zero, `bus_valid` stays 0 and `bus_id` stays 0. A request that arrives later in the same phase wins on the next edge, as in R2.
- R4: Once `bus_valid` is high, `bus_id` and `bus_valid` stay constant at every edge where `arb_phase` is high and at least one request is set, even when a slot with higher priority starts requesting.
- R5: If every request drops while `bus_valid` is high and `arb_phase` is high, then `bus_valid` and `bus_id` return to 0 on the next edge, and arbitration restarts as in R2.
- R6: At any edge where `arb_phase` is low, `bus_valid` and `bus_id` are cleared to 0 whatever the requests are.
- R7: `slot_match[i]` is 1 exactly when `bus_valid` is 1 and `bus_id` equals i. At most one bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_phase | input | 1 | High during the idle or transmit-collision arbitration window |
| slot_req | input | NUM_SLOTS | Request line from each backplane slot, bit i is slot i |
| bus_id | output | ID_W | Registered slot number of the winner on the arbitration bus |
| bus_valid | output | 1 | Registered flag, high while `bus_id` names a winner |
| slot_match | output | NUM_SLOTS | Per-slot flag: this slot owns the winning port |

## Verification
Two things can happen on the same edge: a slot with higher priority can start requesting while a winner is already latched, and the phase can end while requests are still present. The bench latches every request pattern, then raises all eight requests on the next edge and checks that the latched number does not move. It then lowers the phase with all requests still high and checks that the bus is cleared. A third case drops every request while a winner is held, and checks that the bus is released and a later request wins cleanly.

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter  int NUM_SLOTS = 8,
  localparam int ID_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arb_phase,
  input  logic [NUM_SLOTS-1:0] slot_req,
  output logic [ID_W-1:0]      bus_id,
  output logic                 bus_valid,
  output logic [NUM_SLOTS-1:0] slot_match
);

  logic            any_req;
  logic [ID_W-1:0] winner;

  assign any_req = |slot_req;

  always_comb begin
    winner = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (slot_req[i]) winner = ID_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !arb_phase) begin
      bus_valid <= 1'b0;
      bus_id    <= '0;
    end else if (!bus_valid) begin
      if (any_req) begin
        bus_valid <= 1'b1;
        bus_id    <= winner;
      end
    end else if (!any_req) begin
      bus_valid <= 1'b0;
      bus_id    <= '0;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_match
    assign slot_match[g] = bus_valid && (bus_id == ID_W'(g));
  end

  // R2: a fresh winner comes from a phase with requests, and no lower index was requesting
  a_r2_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(arb_phase && (|slot_req)));
  a_r2_winner_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> ((($past(slot_req) >> bus_id) & NUM_SLOTS'(1)) != '0));
  a_r2_no_better_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |->
      (($past(slot_req) & ((NUM_SLOTS'(1) << bus_id) - NUM_SLOTS'(1))) == '0));
  // R4: the latched winner holds through the phase
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && arb_phase && (|slot_req)) |=> (bus_valid && $stable(bus_id)));
  // R5: the bus is released when every request is gone
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !(|slot_req)) |=> !bus_valid);
  // R6: the bus is cleared outside the phase
  a_r6_phase_off: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_phase |=> (!bus_valid && bus_id == '0));
  // R7: at most one board sees a match
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_match) && (bus_valid == (|slot_match)));

endmodule

// File: tb/slot_arbiter_tb.sv
module slot_arbiter_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         arb_phase;
  logic [N-1:0] slot_req;
  logic [2:0]   bus_id;
  logic         bus_valid;
  logic [N-1:0] slot_match;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  slot_arbiter #(.NUM_SLOTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .arb_phase(arb_phase), .slot_req(slot_req),
    .bus_id(bus_id), .bus_valid(bus_valid), .slot_match(slot_match)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic expect_bus(input string rq, input bit v, input int id);
    int m;
    m = v ? (1 << id) : 0;
    chk(bus_valid == v, {rq, " valid"}, int'(bus_valid), int'(v));
    chk(int'(bus_id) == (v ? id : 0), {rq, " id"}, int'(bus_id), v ? id : 0);
    chk(int'(slot_match) == m, {rq, " match R7"}, int'(slot_match), m);
  endtask

  function automatic int lowest(input int p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return 0;
  endfunction

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arb_phase = 1'b1; slot_req = 8'hFF;
    repeat (3) @(negedge clk);
    expect_bus("R1 in reset", 1'b0, 0);
    rst_n = 1'b1; arb_phase = 1'b0; slot_req = '0;
    @(negedge clk);
    expect_bus("R1 after reset", 1'b0, 0);

    // R2 / R4 / R6 sweep over all non-zero request patterns
    for (int p = 1; p < (1 << N); p++) begin
      slot_req = N'(p); arb_phase = 1'b0;
      @(negedge clk);
      arb_phase = 1'b1;
      @(negedge clk);
      expect_bus("R2 winner", 1'b1, lowest(p));
      slot_req = 8'hFF;
      @(negedge clk);
      expect_bus("R4 hold", 1'b1, lowest(p));
      arb_phase = 1'b0;
      @(negedge clk);
      expect_bus("R6 phase off", 1'b0, 0);
    end

    // R3: no requests inside the phase, then a late arrival
    slot_req = '0; arb_phase = 1'b1;
    repeat (3) begin
      @(negedge clk);
      expect_bus("R3 empty", 1'b0, 0);
    end
    slot_req = 8'h30;
    @(negedge clk);
    expect_bus("R3 late request", 1'b1, 4);

    // R5: release and re-arbitration within one phase
    arb_phase = 1'b0; slot_req = 8'h04;
    @(negedge clk);
    arb_phase = 1'b1;
    @(negedge clk);
    expect_bus("R5 lock", 1'b1, 2);
    slot_req = '0;
    @(negedge clk);
    expect_bus("R5 release", 1'b0, 0);
    slot_req = 8'h80;
    @(negedge clk);
    expect_bus("R5 rearbitrate", 1'b1, 7);

    // R6: requests ignored while the phase is low
    arb_phase = 1'b0; slot_req = 8'h01;
    repeat (2) begin
      @(negedge clk);
      expect_bus("R6 ignored", 1'b0, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule